// File: doc/BRIEF.md
# Floating-point predicate compare unit

This unit compares two IEEE-754 operands, either both single precision or both double precision, and reduces the pair to one of four relations: less, equal, greater or unordered. A 3-bit predicate code then picks which union of those relations counts as true. The resulting condition bit is written into a shared 32-bit status word on the clock edge that samples the valid strobe. The same write clears the other top status bits and leaves the low bits untouched.

The compare is quiet. A quiet NaN only makes the pair unordered. A signalling NaN also sets a sticky invalid flag, which stays set until reset. Other owners of the status word can load it whole through a load port. When a load and a compare fall in the same cycle, the compare's rule is applied over the loaded value.

Top module: `fpcmp_unit`

## Requirements
- R1: While reset is asserted and directly after it, the status word reads 0 and the invalid flag reads 0.
- R2: The predicate code selects the relations that make the condition true. Code 1 is unordered, 2 is equal, 3 is unordered or equal, 4 is less, 5 is unordered or less, 6 is less or equal, and 7 is anything but greater. Code bit 0 admits unordered, bit 1 admits equal and bit 2 admits less.
- R3: If either operand is a NaN (exponent all ones, fraction nonzero), the relation is unordered. A quiet NaN (fraction MSB 1) does not set the invalid flag.
- R4: Positive zero and negative zero compare equal in both precisions.
- R5: Non-NaN operands are ordered by signed value. This covers negative numbers, denormals and both infinities.
- R6: One clock after a cycle with cmp_valid high, status bit 29 holds the condition. Status bits 31, 30 and 28 read 0, and bits 27:0 keep their previous value.
- R7: A signalling NaN operand (fraction MSB 0, fraction nonzero) gives an unordered relation and sets invalid_flag one clock later. The flag then stays set through later compares until reset.
- R8: With prec_dbl low, only bits 31:0 of each operand are compared as single precision and bits 63:32 are ignored. With prec_dbl high, all 64 bits are compared as double precision.
- R9: A cycle with ld_en high and cmp_valid low loads ld_data into the status word one clock later. If both are high, the status becomes ld_data with the compare rule of R6 applied on top.
- R10: In a cycle with neither cmp_valid nor ld_en high, the status word and invalid flag do not change, whatever the operand inputs do.
- R11: Predicate code 0 always writes a condition of 0, including for unordered pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a | input | 64 | First operand; single precision uses bits 31:0 |
| op_b | input | 64 | Second operand; single precision uses bits 31:0 |
| prec_dbl | input | 1 | 1 selects double precision, 0 single |
| pred_code | input | 3 | Predicate selector |
| cmp_valid | input | 1 | Compare strobe, sampled on the rising edge |
| ld_en | input | 1 | Load the whole status word |
| ld_data | input | 32 | Value for a status load |
| status_q | output | 32 | Status word read-back |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
The bench runs every operand pair through all eight predicate codes. The pairs include signed zeros, negative pairs, infinities, denormals and both kinds of NaN. These catch a unit that calls -0 and +0 different, orders negatives by raw magnitude, or treats NaN as a large number. Quiet and signalling NaNs are checked apart, so a unit that raises invalid on any NaN, or loses the sticky bit on the next compare, is caught. The bench preloads ones into the low and top status bits. A design that clobbers bits 27:0 or fails to clear bits 31, 30 and 28 then shows a wrong word. Single-precision vectors with junk in the upper halves expose a unit that reads the wrong bits.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_e;

  localparam int PRED_W = 3;

  // Bit positions inside the predicate code; behaviour depends on them.
  localparam int PB_UN = 0;
  localparam int PB_EQ = 1;
  localparam int PB_LT = 2;

endpackage

// File: rtl/fpcmp_class.sv
module fpcmp_class #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0]   opnd,
  output logic                   is_nan,
  output logic                   is_snan,
  output logic                   is_zero,
  output logic                   sign,
  output logic [EXP_W+MAN_W-1:0] mag
);
  localparam int W = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_ones;
  logic             man_nz;

  always_comb begin
    sign     = opnd[W-1];
    exp_f    = opnd[W-2:MAN_W];
    man_f    = opnd[MAN_W-1:0];
    mag      = opnd[W-2:0];
    exp_ones = &exp_f;
    man_nz   = |man_f;
    is_nan   = exp_ones & man_nz;
    is_snan  = is_nan & ~man_f[MAN_W-1];
    is_zero  = ~(|mag);
  end

endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] op_a,
  input  logic [EXP_W+MAN_W:0] op_b,
  output rel_e                 rel,
  output logic                 any_snan
);
  localparam int W = EXP_W + MAN_W + 1;
  localparam int N_OPS = 2;

  logic [W-1:0] ops     [N_OPS];
  logic         nan_v   [N_OPS];
  logic         snan_v  [N_OPS];
  logic         zero_v  [N_OPS];
  logic         sign_v  [N_OPS];
  logic [W-2:0] mag_v   [N_OPS];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
    fpcmp_class #(
      .EXP_W (EXP_W),
      .MAN_W (MAN_W)
    ) u_cls (
      .opnd    (ops[gi]),
      .is_nan  (nan_v[gi]),
      .is_snan (snan_v[gi]),
      .is_zero (zero_v[gi]),
      .sign    (sign_v[gi]),
      .mag     (mag_v[gi])
    );
  end

  logic mag_lt;
  logic mag_eq;

  always_comb begin
    mag_lt   = mag_v[0] < mag_v[1];
    mag_eq   = mag_v[0] == mag_v[1];
    any_snan = snan_v[0] | snan_v[1];
    if (nan_v[0] | nan_v[1]) begin
      rel = REL_UN;
    end else if (zero_v[0] & zero_v[1]) begin
      rel = REL_EQ;
    end else if (sign_v[0] != sign_v[1]) begin
      rel = sign_v[0] ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel = REL_EQ;
    end else if (mag_lt ^ sign_v[0]) begin
      rel = REL_LT;
    end else begin
      rel = REL_GT;
    end
  end

endmodule

// File: rtl/fpcmp_pred.sv
module fpcmp_pred
  import fpcmp_pkg::*;
(
  input  logic [PRED_W-1:0] code,
  input  rel_e              rel,
  output logic              cond
);
  always_comb begin
    unique case (rel)
      REL_UN:  cond = code[PB_UN];
      REL_EQ:  cond = code[PB_EQ];
      REL_LT:  cond = code[PB_LT];
      default: cond = 1'b0;
    endcase
  end

endmodule

// File: rtl/fpcmp_unit.sv
module fpcmp_unit
  import fpcmp_pkg::*;
#(
  parameter int SP_EXP   = 8,
  parameter int SP_MAN   = 23,
  parameter int DP_EXP   = 11,
  parameter int DP_MAN   = 52,
  parameter int STAT_W   = 32,
  parameter int COND_BIT = 29,
  parameter int CLR_LSB  = 28,
  parameter int SYNC_N   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DP_EXP+DP_MAN:0]      op_a,
  input  logic [DP_EXP+DP_MAN:0]      op_b,
  input  logic                        prec_dbl,
  input  logic [PRED_W-1:0]           pred_code,
  input  logic                        cmp_valid,
  input  logic                        ld_en,
  input  logic [STAT_W-1:0]           ld_data,
  output logic [STAT_W-1:0]           status_q,
  output logic                        invalid_flag
);
  localparam int SP_W = SP_EXP + SP_MAN + 1;
  localparam logic [STAT_W-1:0] TOP_MASK = {STAT_W{1'b1}} << CLR_LSB;

  // Reset synchronizer: asserts asynchronously, releases on the clock.
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  // Relation per precision.
  rel_e rel_sp, rel_dp, rel_sel;
  logic snan_sp, snan_dp, snan_sel;

  fpcmp_order #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) u_ord_sp (
    .op_a     (op_a[SP_W-1:0]),
    .op_b     (op_b[SP_W-1:0]),
    .rel      (rel_sp),
    .any_snan (snan_sp)
  );

  fpcmp_order #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) u_ord_dp (
    .op_a     (op_a),
    .op_b     (op_b),
    .rel      (rel_dp),
    .any_snan (snan_dp)
  );

  always_comb begin
    rel_sel  = prec_dbl ? rel_dp  : rel_sp;
    snan_sel = prec_dbl ? snan_dp : snan_sp;
  end

  logic cond;

  fpcmp_pred u_pred (
    .code (pred_code),
    .rel  (rel_sel),
    .cond (cond)
  );

  // Next state.
  logic [STAT_W-1:0] stat_base, stat_d;
  logic              inv_d;
  logic              stat_en, inv_en;

  always_comb begin
    stat_base = ld_en ? ld_data : status_q;
    stat_d    = stat_base;
    if (cmp_valid) begin
      stat_d           = stat_base & ~TOP_MASK;
      stat_d[COND_BIT] = cond;
    end
    stat_en = cmp_valid | ld_en;
    inv_en  = cmp_valid & snan_sel;
    inv_d   = 1'b1;
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status_q <= '0;
    end else if (stat_en) begin
      status_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      invalid_flag <= 1'b0;
    end else if (inv_en) begin
      invalid_flag <= inv_d;
    end
  end

  AST_PRED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_valid && pred_code == '0 |=> !status_q[COND_BIT]); // R11
  AST_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_valid |=> ((status_q & TOP_MASK & ~(STAT_W'(1) << COND_BIT)) == '0)); // R6
  AST_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_valid && !ld_en |=> (status_q & ~TOP_MASK) == ($past(status_q) & ~TOP_MASK)); // R6
  AST_UNORD_PRED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_valid && rel_sel == REL_UN && pred_code == PRED_W'(1) |=> status_q[COND_BIT]); // R3
  AST_QUIET_NAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmp_valid && !snan_sel && !invalid_flag |=> !invalid_flag); // R3
  AST_INV_STICKY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    invalid_flag |=> invalid_flag); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmp_valid && !ld_en |=> $stable(status_q)); // R10

endmodule

// File: tb/sim_fpcmp_unit.sv
module sim_fpcmp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int LT = 0, EQ = 1, GT = 2, UN = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] op_a, op_b;
  logic        prec_dbl;
  logic [2:0]  pred_code;
  logic        cmp_valid, ld_en;
  logic [31:0] ld_data;
  logic [31:0] status_q;
  logic        invalid_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] m_stat;
  bit          m_inv;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prec_dbl(prec_dbl),
    .pred_code(pred_code), .cmp_valid(cmp_valid), .ld_en(ld_en),
    .ld_data(ld_data), .status_q(status_q), .invalid_flag(invalid_flag)
  );

  task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic bit exp_cond(int code, int rel);
    case (code)
      0: return 1'b0;
      1: return rel == UN;
      2: return rel == EQ;
      3: return rel == UN || rel == EQ;
      4: return rel == LT;
      5: return rel == LT || rel == UN;
      6: return rel == LT || rel == EQ;
      default: return rel != GT;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; cmp_valid = 1'b0; ld_en = 1'b0; ld_data = '0;
    op_a = '0; op_b = '0; prec_dbl = 1'b0; pred_code = '0;
    repeat (3) @(negedge clk);
    check32("R1 status in reset", status_q, 32'h0);
    check32("R1 invalid in reset", {31'h0, invalid_flag}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check32("R1 status after reset", status_q, 32'h0);
    m_stat = '0; m_inv = 1'b0;
  endtask

  task automatic do_load(logic [31:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
    m_stat = val;
    check32("R9 load", status_q, m_stat);
  endtask

  // One compare, all checks on status and invalid flag.
  task automatic cmp_one(string req, logic [63:0] a, logic [63:0] b, bit dbl,
                         int code, int rel, bit snan);
    @(negedge clk);
    op_a = a; op_b = b; prec_dbl = dbl; pred_code = 3'(code); cmp_valid = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    m_stat = {2'b00, exp_cond(code, rel), 1'b0, m_stat[27:0]};
    m_inv  = m_inv | snan;
    check32($sformatf("%s code%0d status", req, code), status_q, m_stat);
    check32($sformatf("%s code%0d invalid R7", req, code), {31'h0, invalid_flag}, {31'h0, m_inv});
  endtask

  task automatic cmp_all(string req, logic [63:0] a, logic [63:0] b, bit dbl,
                         int rel, bit snan);
    for (int c = 0; c < 8; c++) cmp_one(req, a, b, dbl, c, rel, snan);
  endtask

  task automatic t_single_order();
    do_load(32'hF5A5A5A5);                                       // R6 top bits set
    cmp_all("R5 sp 1<2", 64'h3F800000, 64'h40000000, 0, LT, 0);
    cmp_all("R5 sp 2>1", 64'h40000000, 64'h3F800000, 0, GT, 0);
    cmp_all("R5 sp -1<1", 64'hBF800000, 64'h3F800000, 0, LT, 0);
    cmp_all("R5 sp -1>-2", 64'hBF800000, 64'hC0000000, 0, GT, 0);
    cmp_all("R5 sp inf>denorm", 64'h7F800000, 64'h00000001, 0, GT, 0);
    cmp_all("R5 sp -inf<-0", 64'hFF800000, 64'h80000000, 0, LT, 0);
    cmp_all("R2 sp eq", 64'h3F800000, 64'h3F800000, 0, EQ, 0);
    cmp_all("R4 sp +0=-0", 64'h00000000, 64'h80000000, 0, EQ, 0);
  endtask

  task automatic t_double_order();
    do_load(32'h3C0FFEE1);
    cmp_all("R5 dp 1<2", 64'h3FF0000000000000, 64'h4000000000000000, 1, LT, 0);
    cmp_all("R5 dp -2<1", 64'hC000000000000000, 64'h3FF0000000000000, 1, LT, 0);
    cmp_all("R4 dp -0=+0", 64'h8000000000000000, 64'h0, 1, EQ, 0);
  endtask

  task automatic t_precision();
    do_load(32'h00000000);
    // R8: upper halves hold a double NaN pattern; single mode must ignore it.
    cmp_all("R8 sp ignores hi", {32'hFFFFFFFF, 32'h3F800000}, {32'h7FF80000, 32'h40000000}, 0, LT, 0);
    cmp_all("R8 dp uses hi", {32'hFFFFFFFF, 32'h3F800000}, {32'h00000000, 32'h40000000}, 1, UN, 0);
  endtask

  task automatic t_quiet_nan();
    cmp_all("R3 sp qnan", 64'h7FC00000, 64'h3F800000, 0, UN, 0);
    cmp_all("R3 dp qnan", 64'h0, 64'h7FF8000000000000, 1, UN, 0);
    cmp_one("R11 pred0 on nan", 64'h7FC00000, 64'h7FC00000, 0, 0, UN, 0);
  endtask

  task automatic t_sig_nan();
    cmp_all("R7 sp snan", 64'h3F800000, 64'h7F800001, 0, UN, 1);
    cmp_all("R7 sticky after", 64'h3F800000, 64'h3F800000, 0, EQ, 0);
    do_reset();
    cmp_all("R7 dp snan", 64'h7FF0000000000001, 64'h0, 1, UN, 1);
  endtask

  task automatic t_load_and_cmp();
    @(negedge clk);
    ld_en = 1'b1; ld_data = 32'h12345678; cmp_valid = 1'b1;
    op_a = 64'h3F800000; op_b = 64'h3F800000; prec_dbl = 1'b0; pred_code = 3'd7;
    @(negedge clk);
    ld_en = 1'b0; cmp_valid = 1'b0;
    m_stat = 32'h22345678;
    check32("R9 load with compare", status_q, m_stat);
  endtask

  task automatic t_idle();
    do_load(32'hFFFFFFFF);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      op_a = 64'(i) * 64'h1111; op_b = 64'h7FC00000; pred_code = 3'(i);
      prec_dbl = i[0];
      @(negedge clk);
      check32("R10 idle status", status_q, m_stat);
      check32("R10 idle invalid", {31'h0, invalid_flag}, {31'h0, m_inv});
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    do_reset();
    t_single_order();
    t_double_order();
    t_precision();
    t_quiet_nan();
    t_load_and_cmp();
    t_idle();
    t_sig_nan();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

endmodule